// File: doc/BRIEF.md
# System Tick Countdown Timer

A periodic down-counter for a processor subsystem. It holds a 24-bit count that steps down by one on each strobe of a chosen clock enable: either a core-rate strobe or a slower reference-rate strobe. A control bit selects the strobe. When the count passes zero, the counter takes the reload value again, a sticky expiry flag is set and, if software asked for it, a one-cycle interrupt request is raised. A zero reload value makes the timer fire once and then switch itself off.

Software drives the timer through a small synchronous strobe bus. There are four word registers. Offset 0x10 holds control and status. Offset 0x14 holds the reload value. Offset 0x18 holds the current count. Offset 0x1c holds calibration. Read data is registered and appears in the cycle after the access. Both clock enables arrive as input strobes. Clock generation and interrupt routing sit outside the block.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register, the flag, the reload value and the visible count all read as zero, and both irq_o and bus_err_o are low.
- R2: In the control register, bit 0 enables counting. Bit 1 enables the interrupt request. Bit 2 picks the count strobe: 1 selects core_tick_i and 0 selects ref_tick_i. Only these three bits are writable. All other bits read zero, except bit 16, which is the flag and cannot be written.
- R3: When counting is switched on, the counter loads the reload value. On each strobe of the selected source it steps down by one, and the strobe that finds it at zero reloads it. This gives one expiry every reload+1 strobes. Strobes of the unselected source have no effect.
- R4: On expiry the flag (control bit 16) is set. irq_o goes high for exactly one cycle, in the cycle after the expiring strobe, and only when control bit 1 is set.
- R5: A read of the control register returns the flag and then clears it. An expiry in the same cycle as the read leaves the flag set.
- R6: A write of any data to the current-value register (0x18) reloads the counter and clears the flag.
- R7: If the reload value is zero at expiry, control bit 0 clears itself and counting stops.
- R8: A control write that changes bit 2 while counting is enabled reloads the counter. A write that leaves bit 2 unchanged does not reload it.
- R9: While counting is disabled, the current-value register reads zero.
- R10: Reload writes keep data bits [23:0]. Reads of the reload and current-value registers return zero in bits [31:24].
- R11: The calibration register (0x1c) reads zero, and writes to it have no effect.
- R12: An access to any other offset, including an offset that is not word-aligned, returns zero and drives bus_err_o high for the cycle after the access.
- R13: bus_rdata_o shows the read value from the cycle after the read access and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_tick_i | input | 1 | Core-rate count strobe |
| ref_tick_i | input | 1 | Reference-rate count strobe |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_err_o | output | 1 | One-cycle pulse after an unmapped access |
| irq_o | output | 1 | One-cycle interrupt request on expiry |

## Verification
Some properties are checked on every cycle:
- the interrupt pulse never lasts two cycles and always comes with the flag;
- a zero-reload expiry clears the enable;
- a current-value write leaves the flag clear;
- the count holds when no strobe or write arrives;
- an error pulse always follows an access;
- read data holds between reads.

The bench scenarios are needed for the arithmetic behaviour:
- the reload+1 period across a sweep of reload values;
- ignoring of the unselected strobe;
- reload on a change of source;
- clear-on-read of the flag;
- masking of reload and control bits;
- decoding of the calibration and unmapped offsets.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned OFS_CTRL = 32'h10;
  localparam int unsigned OFS_RLD  = 32'h14;
  localparam int unsigned OFS_CUR  = 32'h18;
  localparam int unsigned OFS_CAL  = 32'h1c;
  localparam int unsigned FLAG_BIT = 16;

  // control bits: en at [0], ie at [1], src at [2]
  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RLD,
    SEL_CUR,
    SEL_CAL
  } reg_sel_e;
endpackage

// File: rtl/tick_timer_count.sv
module tick_timer_count
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_tick_i,
  input  logic             ref_tick_i,
  input  logic             ctrl_we_i,
  input  ctrl_t            ctrl_wdata_i,
  input  logic             ctrl_rd_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] rld_wdata_i,
  input  logic             cur_we_i,
  output ctrl_t            ctrl_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q, ctrl_n;
  logic             flag_q, flag_n;
  logic             irq_q, irq_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] rld_q, rld_n;
  logic             tick_sel;

  assign tick_sel = ctrl_q.src ? core_tick_i : ref_tick_i;

  always_comb begin
    ctrl_n = ctrl_q;
    cnt_n  = cnt_q;
    flag_n = flag_q & ~ctrl_rd_i;
    irq_n  = 1'b0;
    rld_n  = rld_we_i ? rld_wdata_i : rld_q;
    if (ctrl_we_i) begin
      ctrl_n = ctrl_wdata_i;
      if (ctrl_wdata_i.en && (!ctrl_q.en || (ctrl_wdata_i.src != ctrl_q.src)))
        cnt_n = rld_q;
    end else if (cur_we_i) begin
      cnt_n  = rld_q;
      flag_n = 1'b0;
    end else if (ctrl_q.en && tick_sel) begin
      if (cnt_q == '0) begin
        cnt_n  = rld_q;
        flag_n = 1'b1;
        irq_n  = ctrl_q.ie;
        if (rld_q == '0) ctrl_n.en = 1'b0;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      rld_q  <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      flag_q <= flag_n;
      irq_q  <= irq_n;
      cnt_q  <= cnt_n;
      rld_q  <= rld_n;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign reload_o = rld_q;
  assign count_o  = ctrl_q.en ? cnt_q : '0;
  assign irq_o    = irq_q;

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R4
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);
  // R7
  oneshot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && ($past(rld_q) == '0)) |-> !ctrl_q.en);
  // R6
  cur_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_we_i |=> !flag_q);
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we_i && !cur_we_i && !tick_sel) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_bus.sv
module tick_timer_bus
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_t             ctrl_i,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              ctrl_we_o,
  output logic              ctrl_rd_o,
  output logic              rld_we_o,
  output logic              cur_we_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  reg_sel_e          rsel;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic              err_q, err_n;

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_CTRL)) rsel = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFS_RLD))  rsel = SEL_RLD;
    else if (addr_i == ADDR_W'(OFS_CUR))  rsel = SEL_CUR;
    else if (addr_i == ADDR_W'(OFS_CAL))  rsel = SEL_CAL;
    else                                  rsel = SEL_NONE;
  end

  assign ctrl_we_o = sel_i &&  wr_i && (rsel == SEL_CTRL);
  assign ctrl_rd_o = sel_i && !wr_i && (rsel == SEL_CTRL);
  assign rld_we_o  = sel_i &&  wr_i && (rsel == SEL_RLD);
  assign cur_we_o  = sel_i &&  wr_i && (rsel == SEL_CUR);

  always_comb begin
    rd_val = '0;
    case (rsel)
      SEL_CTRL: begin
        rd_val[2:0]      = ctrl_i;
        rd_val[FLAG_BIT] = flag_i;
      end
      SEL_RLD: rd_val = DATA_W'(reload_i);
      SEL_CUR: rd_val = DATA_W'(count_i);
      default: rd_val = '0;
    endcase
  end

  always_comb begin
    rdata_n = (sel_i && !wr_i) ? rd_val : rdata_q;
    err_n   = sel_i && (rsel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_n;
      err_q   <= err_n;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R12
  err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(sel_i));
  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_i && !wr_i) |=> $stable(rdata_q));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we_o, ctrl_rd_o, rld_we_o, cur_we_o}));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_tick_i,
  input  logic              ref_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  output logic              irq_o
);
  logic             ctrl_we, ctrl_rd, rld_we, cur_we;
  ctrl_t            ctrl;
  ctrl_t            ctrl_wdata;
  logic             flag;
  logic [CNT_W-1:0] reload, count;

  assign ctrl_wdata = bus_wdata_i[2:0];

  tick_timer_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .ctrl_i   (ctrl),
    .flag_i   (flag),
    .reload_i (reload),
    .count_i  (count),
    .ctrl_we_o(ctrl_we),
    .ctrl_rd_o(ctrl_rd),
    .rld_we_o (rld_we),
    .cur_we_o (cur_we),
    .rdata_o  (bus_rdata_o),
    .err_o    (bus_err_o)
  );

  tick_timer_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_tick_i (core_tick_i),
    .ref_tick_i  (ref_tick_i),
    .ctrl_we_i   (ctrl_we),
    .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rd_i   (ctrl_rd),
    .rld_we_i    (rld_we),
    .rld_wdata_i (bus_wdata_i[CNT_W-1:0]),
    .cur_we_i    (cur_we),
    .ctrl_o      (ctrl),
    .flag_o      (flag),
    .reload_o    (reload),
    .count_o     (count),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_tick = 1'b0;
  logic        ref_tick = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd_v;
  logic        err_v;
  logic        irq_v;

  always #5 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .core_tick_i(core_tick), .ref_tick_i(ref_tick),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_err_o(err), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(logic w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    rd_v = rdata; err_v = err;
  endtask

  task automatic rd(logic [7:0] a);
    access(1'b0, a, 32'h0);
  endtask

  task automatic wrt(logic [7:0] a, logic [31:0] d);
    access(1'b1, a, d);
  endtask

  task automatic tick(logic core);
    @(negedge clk);
    if (core) core_tick = 1'b1; else ref_tick = 1'b1;
    @(negedge clk);
    core_tick = 1'b0; ref_tick = 1'b0;
    irq_v = irq;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 err", {31'b0, err}, 32'h0);
    rd(8'h10); check("R1 ctrl", rd_v, 32'h0);
    rd(8'h14); check("R1 reload", rd_v, 32'h0);
    rd(8'h18); check("R1 current", rd_v, 32'h0);

    // R10 reload masking
    wrt(8'h14, 32'hFFFF_FFFF);
    rd(8'h14); check("R10 reload mask", rd_v, 32'h00FF_FFFF);
    // R2 only [2:0] writable
    wrt(8'h10, 32'hFFFF_FFF8);
    rd(8'h10); check("R2 upper ctrl bits", rd_v, 32'h0);
    wrt(8'h10, 32'h0000_0006);
    rd(8'h10); check("R2 ctrl bits", rd_v, 32'h6);
    wrt(8'h10, 32'h0);
    // R11 calibration
    wrt(8'h1c, 32'h1234_5678);
    check("R11 write err", {31'b0, err_v}, 32'h0);
    rd(8'h1c); check("R11 cal read", rd_v, 32'h0);
    rd(8'h14); check("R11 reload untouched", rd_v, 32'h00FF_FFFF);
    // R12 unmapped
    rd(8'h20); check("R12 read data", rd_v, 32'h0);
    check("R12 read err", {31'b0, err_v}, 32'h1);
    wrt(8'h04, 32'hFFFF_FFFF); check("R12 write err", {31'b0, err_v}, 32'h1);
    rd(8'h11); check("R12 misaligned err", {31'b0, err_v}, 32'h1);
    rd(8'h10); check("R12 mapped no err", {31'b0, err_v}, 32'h0);
    // R13 hold
    rd(8'h14);
    repeat (4) @(negedge clk);
    check("R13 hold", rdata, 32'h00FF_FFFF);

    // R3 R4 R5 R7 R9 sweep reload 0..6
    for (int r = 0; r <= 6; r++) begin
      wrt(8'h14, r);
      wrt(8'h10, 32'h7);
      rd(8'h18); check("R3 load on enable", rd_v, r);
      for (int k = 1; k <= r; k++) begin
        tick(1'b1);
        check("R4 no early irq", {31'b0, irq_v}, 32'h0);
        rd(8'h18); check("R3 decrement", rd_v, r - k);
        tick(1'b0);
        rd(8'h18); check("R3 unselected ignored", rd_v, r - k);
      end
      tick(1'b1);
      check("R4 irq at expiry", {31'b0, irq_v}, 32'h1);
      @(negedge clk);
      check("R4 irq one cycle", {31'b0, irq}, 32'h0);
      if (r == 0) begin
        rd(8'h10); check("R7 self disable", rd_v, 32'h0001_0006);
        rd(8'h18); check("R9 disabled reads zero", rd_v, 32'h0);
      end else begin
        rd(8'h10); check("R5 flag read", rd_v, 32'h0001_0007);
        rd(8'h18); check("R3 reload at expiry", rd_v, r);
      end
      rd(8'h10); check("R5 flag cleared", rd_v[16], 1'b0);
      wrt(8'h10, 32'h0);
      rd(8'h18); check("R9 disabled zero", rd_v, 32'h0);
    end

    // R4 no irq when bit 1 clear
    wrt(8'h14, 32'd2);
    wrt(8'h10, 32'h5);
    for (int k = 0; k < 3; k++) begin
      tick(1'b1);
      check("R4 irq masked", {31'b0, irq_v}, 32'h0);
    end
    rd(8'h10); check("R4 flag without irq", rd_v, 32'h0001_0005);

    // R6 current write reload and flag clear
    wrt(8'h10, 32'h0);
    wrt(8'h14, 32'd5);
    wrt(8'h10, 32'h7);
    repeat (2) tick(1'b1);
    rd(8'h18); check("R6 pre", rd_v, 32'd3);
    wrt(8'h18, 32'h0000_0ABC);
    rd(8'h18); check("R6 reload", rd_v, 32'd5);
    repeat (6) tick(1'b1);
    wrt(8'h18, 32'hFFFF_FFFF);
    rd(8'h10); check("R6 flag clear", rd_v, 32'h7);

    // R8 source change reload
    repeat (3) tick(1'b1);
    rd(8'h18); check("R8 pre", rd_v, 32'd2);
    wrt(8'h10, 32'h3);
    rd(8'h18); check("R8 reload on src change", rd_v, 32'd5);
    tick(1'b1);
    rd(8'h18); check("R8 core ignored", rd_v, 32'd5);
    tick(1'b0);
    rd(8'h18); check("R8 ref counts", rd_v, 32'd4);
    wrt(8'h10, 32'h3);
    rd(8'h18); check("R8 same src no reload", rd_v, 32'd4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule